// File: doc/BRIEF.md
# Burst Parallel Port Receiver

This block is the host end of a 16-bit parallel burst link to an external media device. It makes an interface clock, which also serves as the chip select, by dividing the system clock by 2, 4, 8 or 16. During a burst it receives data words from the device into an eight-entry receive FIFO. Downstream logic drains the FIFO through a valid/ready pair. Software programs a burst length and a capture mode through a small register port. It then starts a burst by writing a start bit, which hardware clears when the burst ends.

The block has a single clock domain. The interface clock is a register toggled by a half-period counter. Every sample of the external data bus is taken on a system-clock edge that the engine selects. The capture mode sets that edge. In early mode a word is taken in the cycle where the interface clock falls. In late mode it is taken at the following rise, and the final word of a burst is taken one half period after the last fall, with no further rise.

Top module: `bport_rx`

## Requirements
- R1: After a synchronous active-low reset, the interface clock is low, no FIFO word is valid, and every register reads zero.
- R2: While a burst runs and the FIFO is not full, the interface clock toggles every 2^DIV system cycles. DIV is control bits [2:1], so the divide ratio is 2, 4, 8 or 16. The first edge is a rise 2^DIV cycles after the start write. The clock is low whenever no burst runs.
- R3: A write to the control register (address 0) with bit 0 set starts a burst only if no burst is running and the write-request input is high. Otherwise that bit has no effect.
- R4: Control bit 0 reads 1 while a burst runs and clears itself when the burst completes. Completion sets the done flag, which is status bit 0 at address 2.
- R5: A burst captures exactly COUNT+1 words, where COUNT is the value at address 1.
- R6: With control bit 3 at 0 (early mode), each word is the bus value in the cycle where the interface clock falls. A burst gives exactly COUNT+1 rising edges.
- R7: With control bit 3 at 1 (late mode), each word is captured at the next rise. The last word is captured one half period after the last fall, with no extra rise, so a burst also gives exactly COUNT+1 rising edges.
- R8: If the write-request input drops while a burst runs, the burst ends at the next edge and the clock returns low. Error flag status bit 1 is set, and no further words are captured.
- R9: When the FIFO holds 8 words, the interface clock and the burst are frozen until space frees. No word is lost.
- R10: Writing 1 to a status bit clears it. A same-cycle set wins over the clear.
- R11: Writes to the control fields or to COUNT while a burst runs are ignored.
- R12: FIFO output words appear in capture order. A word offered with ready low stays valid and unchanged.
- R13: A new burst may be started after one completes, and it continues the device's word stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 count, 2 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| ext_clk_o | output | 1 | Divided interface clock and chip select |
| ext_wreq_i | input | 1 | Device write request, level |
| ext_data_i | input | 16 | Device data bus |
| rx_valid | output | 1 | FIFO head word valid |
| rx_ready | input | 1 | Consumer takes the head word |
| rx_data | output | 16 | FIFO head word |

## Verification
The checks assume that the device changes its data only after it sees a rising interface-clock edge. They also assume that write-request is already high before a start is written. The bench device model follows both rules: it drives a new word once per observed rise, and the only write-request drop happens mid-burst, where it is expected to abort. Bus inputs and register writes are applied between clock edges, so every capture sees a settled value.

// File: rtl/bport_pkg.sv
// Shared register layout and configuration type for the burst port receiver.
// Assumes a 2-bit register address space; field positions are fixed here.
package bport_pkg;
    localparam int DIV_SEL_W = 2;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;
    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_DIV_LSB   = 1;
    localparam int CTRL_LATCH_BIT = CTRL_DIV_LSB + DIV_SEL_W;
    localparam int STAT_DONE_BIT  = 0;
    localparam int STAT_ERR_BIT   = 1;

    typedef struct packed {
        logic                 latch_late;
        logic [DIV_SEL_W-1:0] div_sel;
    } port_cfg_t;
endpackage

// File: rtl/bport_regs.sv
// Register file: control (start, divider, capture mode), burst count, sticky
// done/error flags with write-one-to-clear. Assumes single-cycle writes;
// configuration writes are dropped while a burst is running.
module bport_regs
    import bport_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    input  logic              ext_wreq,
    input  logic              done_set,
    input  logic              err_set,
    output port_cfg_t         cfg,
    output logic [CNT_W-1:0]  burst_last,
    output logic              go,
    output logic              done_q,
    output logic              err_q,
    output logic [REG_W-1:0]  reg_rdata
);
    logic wr_ctrl, wr_count, wr_stat;
    logic unused_wdata;

    assign wr_ctrl  = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_count = reg_we && (reg_addr == ADDR_COUNT);
    assign wr_stat  = reg_we && (reg_addr == ADDR_STAT);
    assign go = wr_ctrl && !busy && ext_wreq && reg_wdata[CTRL_GO_BIT];
    assign unused_wdata = ^reg_wdata;

    // Configuration fields, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            burst_last <= '0;
        end else begin
            if (wr_ctrl && !busy) begin
                cfg.div_sel    <= reg_wdata[CTRL_DIV_LSB +: DIV_SEL_W];
                cfg.latch_late <= reg_wdata[CTRL_LATCH_BIT];
            end
            if (wr_count && !busy)
                burst_last <= reg_wdata[CNT_W-1:0];
        end
    end

    // Sticky flags; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= done_set | (done_q & ~(wr_stat & reg_wdata[STAT_DONE_BIT]));
            err_q  <= err_set  | (err_q  & ~(wr_stat & reg_wdata[STAT_ERR_BIT]));
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_GO_BIT]                 = busy;
                reg_rdata[CTRL_DIV_LSB +: DIV_SEL_W]   = cfg.div_sel;
                reg_rdata[CTRL_LATCH_BIT]              = cfg.latch_late;
            end
            ADDR_COUNT: reg_rdata[CNT_W-1:0] = burst_last;
            ADDR_STAT: begin
                reg_rdata[STAT_DONE_BIT] = done_q;
                reg_rdata[STAT_ERR_BIT]  = err_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bport_engine.sv
// Burst engine: divides the system clock into the interface clock, chooses
// the capture cycle for each word (early or late mode) and ends the burst on
// the last word or on a dropped write request. Assumes cfg and burst_last
// hold still while busy; freezes entirely while the FIFO is full.
module bport_engine
    import bport_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  port_cfg_t         cfg,
    input  logic [CNT_W-1:0]  burst_last,
    input  logic              ext_wreq,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              fifo_full,
    output logic              busy,
    output logic              ext_clk,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              done_set,
    output logic              err_set
);
    localparam int MAX_HALF = 1 << ((1 << DIV_SEL_W) - 1);
    localparam int HC_W     = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    logic [HC_W-1:0]  half_cnt, half_last;
    logic [CNT_W-1:0] word_cnt;
    logic             primed, tick, finish, abort;

    assign half_last = HC_W'((32'd1 << cfg.div_sel) - 32'd1);
    assign tick      = busy && ext_wreq && !fifo_full && (half_cnt == half_last);
    assign push      = tick && (ext_clk ? !cfg.latch_late : (cfg.latch_late && primed));
    assign push_data = ext_data;
    assign finish    = push && (word_cnt == burst_last);
    assign abort     = busy && !ext_wreq;
    assign done_set  = finish;
    assign err_set   = abort;

    // Burst sequencing, interface clock toggling and word counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ext_clk  <= 1'b0;
            half_cnt <= '0;
            word_cnt <= '0;
            primed   <= 1'b0;
        end else if (go) begin
            busy     <= 1'b1;
            ext_clk  <= 1'b0;
            half_cnt <= '0;
            word_cnt <= '0;
            primed   <= 1'b0;
        end else if (abort) begin
            busy    <= 1'b0;
            ext_clk <= 1'b0;
        end else if (busy && !fifo_full) begin
            if (tick) begin
                half_cnt <= '0;
                if (push)
                    word_cnt <= word_cnt + 1'b1;
                if (finish) begin
                    busy    <= 1'b0;
                    ext_clk <= 1'b0;
                end else begin
                    ext_clk <= ~ext_clk;
                    if (ext_clk)
                        primed <= 1'b1;
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bport_fifo.sv
// Receive FIFO with first-word-fall-through output. Assumes the writer never
// pushes while full; a pop and a push may share a cycle.
module bport_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         valid,
    input  logic         ready,
    output logic [W-1:0] data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   fill;
    logic          pop;

    assign full  = (fill == (AW+1)'(DEPTH));
    assign valid = (fill != '0);
    assign pop   = valid && ready;
    assign data  = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    // Pointer and fill tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
        end
    end
endmodule

// File: rtl/bport_rx.sv
// Top of the burst port receiver: register file, burst engine and receive
// FIFO. Single clock domain; the interface clock is a registered output.
module bport_rx
    import bport_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ext_clk_o,
    input  logic              ext_wreq_i,
    input  logic [DATA_W-1:0] ext_data_i,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data
);
    port_cfg_t         cfg;
    logic [CNT_W-1:0]  burst_last;
    logic              go, eng_busy, cap_push, fifo_full;
    logic              done_set, err_set, flag_done, flag_err;
    logic [DATA_W-1:0] cap_data;

    bport_regs #(.REG_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(eng_busy), .ext_wreq(ext_wreq_i),
        .done_set(done_set), .err_set(err_set), .cfg(cfg),
        .burst_last(burst_last), .go(go), .done_q(flag_done),
        .err_q(flag_err), .reg_rdata(reg_rdata)
    );

    bport_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg(cfg), .burst_last(burst_last),
        .ext_wreq(ext_wreq_i), .ext_data(ext_data_i), .fifo_full(fifo_full),
        .busy(eng_busy), .ext_clk(ext_clk_o), .push(cap_push),
        .push_data(cap_data), .done_set(done_set), .err_set(err_set)
    );

    bport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cap_push), .push_data(cap_data),
        .full(fifo_full), .valid(rx_valid), .ready(rx_ready), .data(rx_data)
    );
endmodule

// File: rtl/bport_rx_chk.sv
// Protocol checker for the burst port receiver, bound into the top.
module bport_rx_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              fifo_full,
    input logic              push,
    input logic              flag_done,
    input logic              flag_err,
    input logic              ext_clk_o,
    input logic              ext_wreq_i,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data
);
    a_r2_clk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ext_clk_o);
    a_r3_no_start_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ext_wreq_i) |=> !busy);
    a_r4_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_wreq_i) |=> (busy || flag_done));
    a_r8_drop_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ext_wreq_i) |=> (flag_err && !busy));
    a_r9_freeze_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_wreq_i && fifo_full) |=> $stable(ext_clk_o));
    a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push);
    a_r12_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind bport_rx bport_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .fifo_full(fifo_full),
    .push(cap_push), .flag_done(flag_done), .flag_err(flag_err),
    .ext_clk_o(ext_clk_o), .ext_wreq_i(ext_wreq_i), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/bport_rx_test.sv
// Self-checking bench: a behavioural cycle model is compared on every clock.
module bport_rx_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, we, wreq, ready;
    logic [1:0]  addr;
    logic [15:0] wdata, xdata;
    logic [15:0] reg_rdata, rx_data;
    logic        ext_clk_o, rx_valid;

    bport_rx uut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(reg_rdata), .ext_clk_o(ext_clk_o),
        .ext_wreq_i(wreq), .ext_data_i(xdata), .rx_valid(rx_valid),
        .rx_ready(ready), .rx_data(rx_data)
    );

    int checks = 0, fails = 0;
    bit m_busy, m_clk, m_primed, m_latch, m_done, m_err;
    int m_hc, m_cnt;
    logic [1:0] m_div;
    logic [7:0] m_count;
    logic [15:0] mq[$];
    logic [15:0] got[$];
    int dev_idx, rises;
    logic [15:0] dev_base;
    bit prev_clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl(input logic [1:0] d, input bit l, input bit g);
        return {12'd0, l, d, g};
    endfunction

    function automatic logic [15:0] exp_rd();
        case (addr)
            2'd0: return {12'd0, m_latch, m_div, m_busy};
            2'd1: return {8'd0, m_count};
            2'd2: return {14'd0, m_err, m_done};
            default: return 16'd0;
        endcase
    endfunction

    // Behavioural model of the next clock edge, from the inputs now applied.
    task automatic model_step();
        bit ob, full, cap, fin, sd, se;
        int h;
        ob = m_busy; full = (mq.size() == 8); h = 1 << m_div;
        sd = 0; se = 0;
        if (ready && mq.size() > 0) void'(mq.pop_front());
        if (ob) begin
            if (!wreq) begin
                m_busy = 0; m_clk = 0; se = 1;
            end else if (!full) begin
                if (m_hc == h - 1) begin
                    m_hc = 0;
                    cap = m_clk ? !m_latch : (m_latch && m_primed);
                    fin = cap && (m_cnt == int'(m_count));
                    if (cap) begin mq.push_back(xdata); m_cnt++; end
                    if (fin) begin m_busy = 0; m_clk = 0; sd = 1; end
                    else begin
                        if (m_clk) m_primed = 1;
                        m_clk = !m_clk;
                    end
                end else m_hc++;
            end
        end
        if (we) begin
            case (addr)
                2'd0: if (!ob) begin
                    m_div = wdata[2:1]; m_latch = wdata[3];
                    if (wdata[0] && wreq) begin
                        m_busy = 1; m_hc = 0; m_clk = 0; m_cnt = 0; m_primed = 0;
                    end
                end
                2'd1: if (!ob) m_count = wdata[7:0];
                2'd2: begin
                    if (wdata[0]) m_done = 0;
                    if (wdata[1]) m_err = 0;
                end
                default: ;
            endcase
        end
        if (sd) m_done = 1;
        if (se) m_err = 1;
    endtask

    // One clock: record handshake, advance model, compare at the falling edge, run device.
    task automatic cycle();
        if (rx_valid && ready) got.push_back(rx_data);
        model_step();
        @(negedge clk);
        chk(ext_clk_o === m_clk, "R2 interface clock level", ext_clk_o, m_clk);
        chk(rx_valid === (mq.size() > 0), "R12 valid", rx_valid, mq.size() > 0);
        if (mq.size() > 0) chk(rx_data === mq[0], "R12 head word", rx_data, mq[0]);
        chk(reg_rdata === exp_rd(), "R10 register readback", reg_rdata, exp_rd());
        if (ext_clk_o && !prev_clk) begin
            rises++; dev_idx++; xdata = dev_base + 16'(dev_idx);
        end
        prev_clk = ext_clk_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        we = 1; addr = a; wdata = d; cycle(); we = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
        addr = a; #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && m_busy; i++) cycle();
    endtask

    task automatic drain(input int n);
        ready = 1; repeat (n) cycle(); ready = 0;
    endtask

    task automatic new_dev(input logic [15:0] base);
        dev_base = base; dev_idx = -1; got.delete(); rises = 0;
    endtask

    task automatic chk_words(input int n, input logic [15:0] base, input string req);
        chk(got.size() == n, req, got.size(), n);
        for (int i = 0; i < got.size() && i < n; i++)
            chk(got[i] === base + 16'(i), req, got[i], base + 16'(i));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, r;
        bit c;
        we = 0; addr = 0; wdata = 0; wreq = 0; ready = 0; xdata = 16'hDEAD;
        rst_n = 0; prev_clk = 0; new_dev(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(ext_clk_o === 1'b0, "R1 clock low", ext_clk_o, 0);
        chk(rx_valid === 1'b0, "R1 fifo empty", rx_valid, 0);
        rd_chk(0, 0, "R1 control zero");
        rd_chk(1, 0, "R1 count zero");
        rd_chk(2, 0, "R1 status zero");

        // R3: start ignored without write request
        wr(0, ctrl(0, 0, 1));
        repeat (4) cycle();
        rd_chk(0, 0, "R3 start ignored while request low");
        chk(rises == 0, "R3 no clock edges", rises, 0);

        // R4 R5 R6: early mode, four words
        wreq = 1; new_dev(16'h0100); ready = 1;
        wr(1, 3);
        wr(0, ctrl(0, 0, 1));
        rd_chk(0, 16'h0001, "R4 start bit reads busy");
        wait_idle(); drain(4);
        chk_words(4, 16'h0100, "R5 R6 early capture words");
        chk(rises == 4, "R6 rising edges per burst", rises, 4);
        rd_chk(0, 0, "R4 start bit self cleared");
        rd_chk(2, 1, "R4 done flag set");
        wr(2, 1);
        rd_chk(2, 0, "R10 done cleared by write one");

        // R7: late mode, three words, divide by 4
        new_dev(16'h0200); ready = 1;
        wr(1, 2);
        wr(0, ctrl(1, 1, 1));
        wait_idle(); drain(4);
        chk_words(3, 16'h0200, "R7 late capture words");
        chk(rises == 3, "R7 no extra rise for last word", rises, 3);
        chk(ext_clk_o === 1'b0, "R7 clock low after burst", ext_clk_o, 0);

        // R2: divide by 16 timing
        new_dev(16'h0300); ready = 1;
        wr(1, 0);
        wr(0, ctrl(3, 0, 1));
        n = 0;
        while (!ext_clk_o && n < 50) begin cycle(); n++; end
        chk(n == 8, "R2 first rise after half period", n, 8);
        n = 0;
        while (ext_clk_o && n < 50) begin cycle(); n++; end
        chk(n == 8, "R2 high half period", n, 8);
        wait_idle(); drain(3);
        chk_words(1, 16'h0300, "R5 single word burst");

        // R9: FIFO full freezes the burst
        new_dev(16'h0400); ready = 0;
        wr(1, 11);
        wr(0, ctrl(0, 0, 1));
        repeat (40) cycle();
        rd_chk(0, 16'h0001, "R9 burst held while full");
        r = rises; c = ext_clk_o;
        repeat (10) cycle();
        chk(rises == r && ext_clk_o == c, "R9 clock frozen while full", rises, r);
        ready = 1;
        wait_idle(); drain(10);
        chk_words(12, 16'h0400, "R9 R12 no word lost");

        // R11: configuration writes during a burst are dropped
        new_dev(16'h0500); ready = 1;
        wr(1, 5);
        wr(0, ctrl(1, 0, 1));
        wr(0, ctrl(3, 1, 0));
        wr(1, 9);
        wait_idle(); drain(4);
        chk_words(6, 16'h0500, "R11 count write ignored while busy");
        rd_chk(0, ctrl(1, 0, 0), "R11 control write ignored while busy");
        rd_chk(1, 5, "R11 count unchanged");

        // R8: request dropped mid-burst
        wr(2, 3);
        new_dev(16'h0600); ready = 0;
        wr(1, 9);
        wr(0, ctrl(0, 0, 1));
        repeat (7) cycle();
        wreq = 0;
        cycle(); cycle();
        rd_chk(0, 0, "R8 burst aborted");
        rd_chk(2, 2, "R8 error flag set");
        chk(ext_clk_o === 1'b0, "R8 clock low after abort", ext_clk_o, 0);
        r = rises;
        repeat (5) cycle();
        chk(rises == r, "R8 no edges after abort", rises, r);
        drain(10);
        chk(got.size() > 0 && got.size() < 10, "R8 partial burst", got.size(), 3);
        for (int i = 0; i < got.size(); i++)
            chk(got[i] === 16'h0600 + 16'(i), "R8 captured prefix", got[i], 16'h0600 + 16'(i));
        wr(2, 2);
        rd_chk(2, 0, "R10 error cleared by write one");

        // R13: back-to-back bursts continue the device stream
        wreq = 1; new_dev(16'h0700); ready = 0;
        wr(1, 1);
        wr(0, ctrl(0, 1, 1));
        wait_idle();
        wr(0, ctrl(0, 1, 1));
        wait_idle(); drain(6);
        chk_words(4, 16'h0700, "R13 second burst continues stream");
        rd_chk(2, 1, "R13 done after second burst");

        repeat (3) cycle();
        finish_run();
    end
endmodule